// File: doc/BRIEF.md
# Bus-Injecting Instruction Breakpoint

This block sits beside the host CPU bus and watches every bus cycle. A debug controller loads a 16-bit breakpoint address as two bytes and arms the block. When the host then reads from that address, the block raises the bus inhibit line so that neither RAM nor ROM answers. It drives 0x00, the break opcode, onto the data bus in their place. Execution therefore drops into the monitor at any address, including ROM, and the trap stays in force even if the host later overwrites that location.

The host side registers the address, the read/write level and the cycle strobe on every clock. A three-state machine then decides what to do. DISARMED: matching is off and the outputs are quiet. ARMED: every registered cycle is compared with the breakpoint. INJECT: the inhibit and the data drive are held for the rest of the matching bus cycle. The transitions are as follows. *arm* (DISARMED to ARMED) fires when enable is set. *disarm* (ARMED to DISARMED) fires when enable is cleared. *hit* (ARMED to INJECT) fires on a matching read. *release* (INJECT to ARMED, or to DISARMED if enable was cleared meanwhile) fires when the cycle strobe drops. A sticky hit flag records each match for the controller.

Top module: `bus_break_injector`

## Requirements
- R1: After reset the breakpoint is disabled, `bus_inhibit` and `bus_drive_en` are low, and `hit_flag` is low.
- R2: When enabled and the host holds `host_cyc` high with `host_rnw`=1 at the breakpoint address, `bus_inhibit` and `bus_drive_en` are high two clock edges after the cycle starts and remain high while `host_cyc` stays high.
- R3: During an injected cycle `bus_drive_data` is 0x00.
- R4: Non-matching addresses and write cycles (`host_rnw`=0) at the breakpoint address never raise `bus_inhibit`.
- R5: While disabled, a read at the breakpoint address raises neither `bus_inhibit` nor `bus_drive_en`.
- R6: The address is assembled from register select 0 (low byte) and select 1 (high byte). Select 2 bit 0 is the enable bit.
- R7: A host write to the breakpoint address does not disarm the breakpoint, and the next read there is injected again.
- R8: `hit_flag` is set by each injected cycle and stays set until the controller writes to register select 3.
- R9: Writes to selects 0 and 1 are ignored while the breakpoint is enabled.
- R10: `bus_inhibit` falls within two clock edges after `host_cyc` drops.
- R11: Matching works at the extreme addresses 0x0000 and 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, faster than the host bus |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 16 | Host address bus |
| host_rnw | input | 1 | Host read (1) / write (0) |
| host_cyc | input | 1 | High while a host bus cycle is valid |
| cfg_wr | input | 1 | Debug controller register write strobe |
| cfg_sel | input | 2 | Register select: 0 addr low, 1 addr high, 2 control, 3 clear hit |
| cfg_wdata | input | 8 | Register write data |
| bus_inhibit | output | 1 | Inhibit for onboard memory |
| bus_drive_en | output | 1 | Data bus output enable |
| bus_drive_data | output | 8 | Substituted data byte |
| hit_flag | output | 1 | Sticky breakpoint-hit flag |
| bp_enabled | output | 1 | Current enable bit |

## Verification
The bench checks that a write cycle at the trap address leaves the next read trapped. A design that disarmed on that write would let the original byte through. It checks that neighbouring addresses that differ in one byte only are not trapped. A half-width compare would inhibit them and corrupt normal execution. It checks that address writes made while the trap is armed have no effect, and that the trap releases when the strobe drops. A missing lock would move the trap silently. A late release would hold the bus inhibited into the next cycle.

// File: rtl/bp_pkg.sv
package bp_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int SEL_W  = 2;
    localparam logic [DATA_W-1:0] BRK_OP = '0;

    typedef enum logic [SEL_W-1:0] {
        SEL_ALO   = 2'd0,
        SEL_AHI   = 2'd1,
        SEL_CTRL  = 2'd2,
        SEL_CLRHT = 2'd3
    } cfg_sel_e;

    typedef enum logic [1:0] {
        ST_DISARMED = 2'd0,
        ST_ARMED    = 2'd1,
        ST_INJECT   = 2'd2
    } bp_state_e;
endpackage

// File: rtl/bp_regs.sv
module bp_regs
    import bp_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic [DW-1:0] cfg_wdata,
    input  logic          hit_set,
    output logic [AW-1:0] bp_addr,
    output logic          enable,
    output logic          hit
);
    localparam int HI_W = AW - DW;

    logic wr_lo, wr_hi, wr_ctl, wr_clr;

    always_comb begin
        wr_lo  = cfg_wr && (cfg_sel == SEL_ALO) && !enable;
        wr_hi  = cfg_wr && (cfg_sel == SEL_AHI) && !enable;
        wr_ctl = cfg_wr && (cfg_sel == SEL_CTRL);
        wr_clr = cfg_wr && (cfg_sel == SEL_CLRHT);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bp_addr <= '0;
            enable  <= 1'b0;
            hit     <= 1'b0;
        end else begin
            if (wr_lo) bp_addr[DW-1:0] <= cfg_wdata;
            if (wr_hi) bp_addr[AW-1:DW] <= cfg_wdata[HI_W-1:0];
            if (wr_ctl) enable <= cfg_wdata[0];
            if (hit_set)     hit <= 1'b1;
            else if (wr_clr) hit <= 1'b0;
        end
    end

    // R9
    addr_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !(cfg_wr && cfg_sel == SEL_CTRL)) |=> $stable(bp_addr));
    // R8
    hit_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_set |=> hit);
endmodule

// File: rtl/bp_match.sv
module bp_match
    import bp_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] host_addr,
    input  logic          host_rnw,
    input  logic          host_cyc,
    input  logic [AW-1:0] bp_addr,
    output logic          cyc_q,
    output logic          rd_match
);
    logic [AW-1:0] addr_q;
    logic          rnw_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            rnw_q  <= 1'b0;
            cyc_q  <= 1'b0;
        end else begin
            addr_q <= host_addr;
            rnw_q  <= host_rnw;
            cyc_q  <= host_cyc;
        end
    end

    always_comb rd_match = cyc_q && rnw_q && (addr_q == bp_addr);

    // R4
    match_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_match |-> ($past(host_rnw) && $past(host_cyc)));
endmodule

// File: rtl/bp_fsm.sv
module bp_fsm
    import bp_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          cyc_q,
    input  logic          rd_match,
    output logic          hit_set,
    output logic          inhibit,
    output logic          drive_en,
    output logic [DW-1:0] drive_data
);
    bp_state_e state, nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_DISARMED: if (enable) nxt = ST_ARMED;
            ST_ARMED: begin
                if (!enable)       nxt = ST_DISARMED;
                else if (rd_match) nxt = ST_INJECT;
            end
            ST_INJECT: if (!cyc_q) nxt = enable ? ST_ARMED : ST_DISARMED;
            default:   nxt = ST_DISARMED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_DISARMED;
        else        state <= nxt;
    end

    always_comb begin
        hit_set    = (state == ST_ARMED) && enable && rd_match;
        inhibit    = (state == ST_INJECT);
        drive_en   = (state == ST_INJECT);
        drive_data = BRK_OP;
    end

    // R2
    inj_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_INJECT && cyc_q) |=> inhibit);
    // R10
    inj_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_INJECT && !cyc_q) |=> !inhibit);
    // R5
    disarmed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DISARMED) |-> !drive_en);
endmodule

// File: rtl/bus_break_injector.sv
module bus_break_injector
    import bp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_rnw,
    input  logic              host_cyc,
    input  logic              cfg_wr,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic              bus_inhibit,
    output logic              bus_drive_en,
    output logic [DATA_W-1:0] bus_drive_data,
    output logic              hit_flag,
    output logic              bp_enabled
);
    logic [ADDR_W-1:0] bp_addr;
    logic cyc_q, rd_match, hit_set;

    bp_regs #(.AW(ADDR_W), .DW(DATA_W)) u_regs (
        .clk, .rst_n, .cfg_wr, .cfg_sel, .cfg_wdata, .hit_set,
        .bp_addr, .enable(bp_enabled), .hit(hit_flag)
    );

    bp_match #(.AW(ADDR_W)) u_match (
        .clk, .rst_n, .host_addr, .host_rnw, .host_cyc, .bp_addr,
        .cyc_q, .rd_match
    );

    bp_fsm #(.DW(DATA_W)) u_fsm (
        .clk, .rst_n, .enable(bp_enabled), .cyc_q, .rd_match, .hit_set,
        .inhibit(bus_inhibit), .drive_en(bus_drive_en),
        .drive_data(bus_drive_data)
    );

    // R3
    brk_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_drive_en |-> (bus_drive_data == 8'h00));
endmodule

// File: tb/sim_bus_break_injector.sv
module sim_bus_break_injector;
    logic clk = 1'b0, rst_n = 1'b0;
    logic [15:0] host_addr = '0;
    logic host_rnw = 1'b1, host_cyc = 1'b0;
    logic cfg_wr = 1'b0;
    logic [1:0] cfg_sel = '0;
    logic [7:0] cfg_wdata = '0;
    logic bus_inhibit, bus_drive_en, hit_flag, bp_enabled;
    logic [7:0] bus_drive_data;

    int n_chk = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    bus_break_injector u0 (.*);

    // {addr, rnw, expected inhibit}; trap at 16'hF3A1
    localparam logic [17:0] VEC [7] = '{
        {16'hF3A1, 1'b1, 1'b1},
        {16'hF3A0, 1'b1, 1'b0},
        {16'hF3A1, 1'b0, 1'b0},
        {16'hF3A1, 1'b1, 1'b1},
        {16'h03A1, 1'b1, 1'b0},
        {16'hF2A1, 1'b1, 1'b0},
        {16'hF3A1, 1'b1, 1'b1}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cfg(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = s; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    // One host cycle: strobe high for 4 clocks; returns inhibit seen 2 edges in,
    // at the end of the cycle, and 2 edges after the strobe drops.
    task automatic bus_cycle(input logic [15:0] a, input logic rnw,
                             output logic early, output logic late, output logic after);
        @(negedge clk);
        host_addr = a; host_rnw = rnw; host_cyc = 1'b1;
        @(negedge clk);
        @(negedge clk);
        early = bus_inhibit & bus_drive_en & (bus_drive_data == 8'h00);
        @(negedge clk);
        @(negedge clk);
        late = bus_inhibit & bus_drive_en;
        host_cyc = 1'b0;
        @(negedge clk);
        @(negedge clk);
        after = bus_inhibit | bus_drive_en;
        @(negedge clk);
    endtask

    task automatic set_addr(input logic [15:0] a);
        cfg(2'd0, a[7:0]);
        cfg(2'd1, a[15:8]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic e, l, a;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 enable", {15'd0, bp_enabled}, 16'd0);
        check("R1 inhibit", {14'd0, bus_inhibit, bus_drive_en}, 16'd0);
        check("R1 hit", {15'd0, hit_flag}, 16'd0);

        // R6 address from select 0/1
        set_addr(16'hF3A1);
        // R5 disabled: no injection
        bus_cycle(16'hF3A1, 1'b1, e, l, a);
        check("R5 disabled read", {14'd0, e, l}, 16'd0);
        cfg(2'd2, 8'h01);
        check("R6 enable bit", {15'd0, bp_enabled}, 16'd1);

        // R2 R3 R4 R7 table walk
        for (int i = 0; i < 7; i++) begin
            bus_cycle(VEC[i][17:2], VEC[i][1], e, l, a);
            check(VEC[i][0] ? "R2/R3/R7 trapped read" : "R4 untrapped cycle",
                  {14'd0, e, l}, {14'd0, VEC[i][0], VEC[i][0]});
            // R10 release after strobe drop
            check("R10 release", {15'd0, a}, 16'd0);
        end

        // R8 sticky flag, cleared by select 3
        check("R8 hit set", {15'd0, hit_flag}, 16'd1);
        bus_cycle(16'h1234, 1'b1, e, l, a);
        check("R8 hit sticky", {15'd0, hit_flag}, 16'd1);
        cfg(2'd3, 8'h00);
        check("R8 hit cleared", {15'd0, hit_flag}, 16'd0);

        // R9 address writes ignored while enabled
        set_addr(16'h0000);
        bus_cycle(16'hF3A1, 1'b1, e, l, a);
        check("R9 old address still trapped", {15'd0, e}, 16'd1);
        bus_cycle(16'h0000, 1'b1, e, l, a);
        check("R9 new address not trapped", {15'd0, e}, 16'd0);

        // R11 extremes
        cfg(2'd2, 8'h00);
        set_addr(16'hFFFF);
        cfg(2'd2, 8'h01);
        bus_cycle(16'hFFFF, 1'b1, e, l, a);
        check("R11 0xFFFF trapped", {15'd0, e}, 16'd1);
        bus_cycle(16'hFFFE, 1'b1, e, l, a);
        check("R11 0xFFFE not trapped", {15'd0, e}, 16'd0);
        cfg(2'd2, 8'h00);
        set_addr(16'h0000);
        cfg(2'd2, 8'h01);
        bus_cycle(16'h0000, 1'b1, e, l, a);
        check("R11 0x0000 trapped", {15'd0, e}, 16'd1);

        // R5 after disable
        cfg(2'd2, 8'h00);
        bus_cycle(16'h0000, 1'b1, e, l, a);
        check("R5 disabled again", {14'd0, e, l}, 16'd0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule